// File: doc/BRIEF.md
# Microprogram Sequencer

This block steps a microcoded processor through its control store. A 6-bit micro program counter selects one 15-bit control word out of a 64-entry store, and that word is presented on the output for the whole cycle. Each bit of the word drives one micro-operation elsewhere in the machine. Bits are numbered 1 to 15, and control bit k appears on `ctrl_word[k-1]`. The sequencer itself only interprets bits 1 and 2. Every other bit is passed through to a datapath that lies outside this block.

On each clock the counter does one of three things. It returns to 0 when bit 1 is set. It jumps to a decoded start address when bit 2 is set. Otherwise it steps by one. The start address comes from a 32-entry opcode table indexed by the low 5 bits of the data bus. By convention, address 0 holds the instruction fetch word. That word sets the load bit, so one cycle at address 0 both reads the opcode and dispatches to the routine for that instruction.

Both tables are plain registers with a write port. They are filled while reset is held and may be rewritten later. The current counter value is also brought out.

Top module: `microseq_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `upc` is 0 after that edge.
- R2: `ctrl_word` always equals the control-store entry addressed by `upc`. Control bit k is `ctrl_word[k-1]`, so bit 1 is `ctrl_word[0]` and bit 2 is `ctrl_word[1]`.
- R3: If `ctrl_word[0]` is 1 at a clock edge out of reset, `upc` is 0 after that edge.
- R4: If `ctrl_word[1]` is 1 and `ctrl_word[0]` is 0 at an edge, `upc` takes the opcode-table entry indexed by `bus_lo` at that edge.
- R5: When `ctrl_word[0]` and `ctrl_word[1]` are both 1, the clear wins and `upc` becomes 0.
- R6: When `ctrl_word[1:0]` is 00, `upc` increases by 1 at each edge.
- R7: When `ctrl_word[1:0]` is 00 and `upc` is 63, `upc` becomes 0.
- R8: An opcode-table write (`dec_we`) takes effect at the edge that ends its cycle. A load in that same cycle uses the previous entry.
- R9: A control-store write (`cs_we`) changes `ctrl_word` for that address only from the next cycle. All other entries keep their values.
- R10: When `ctrl_word[1]` is 0, the value on `bus_lo` has no effect on `upc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the micro PC |
| bus_lo | input | 5 | Low bits of the data bus (opcode) |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 6 | Control-store write address |
| cs_wdata | input | 15 | Control-store write word |
| dec_we | input | 1 | Opcode-table write enable |
| dec_waddr | input | 5 | Opcode-table write index |
| dec_wdata | input | 6 | Opcode-table start address |
| ctrl_word | output | 15 | Current control word |
| upc | output | 6 | Current micro PC |

## Verification
The bound checker examines every cycle. It checks that reset, clear, the clear-over-load priority, the decoded load, the step and the wrap at 63 each move the counter as required. It judges each move against the word and decoder output of the cycle before. The checker cannot tell whether the word shown is the right store entry, or whether a write landed on the correct cycle. The bench reference model covers those cases by tracking both tables and comparing the counter and the word every clock. Its scenarios cover several dispatched routines, a rewrite of an opcode entry in the same cycle as a load through it, a store write to the address being executed, and a reset taken in the middle of a routine.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // position of the sequencing bits inside a control word
    localparam int CLR_IDX = 0;   // control bit 1
    localparam int LD_IDX  = 1;   // control bit 2

    typedef enum logic [1:0] {
        ACT_RESET,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_STEP
    } upc_act_e;

endpackage

// File: rtl/useq_table.sv
module useq_table #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 15,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] row;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we && (waddr == AW'(i))) begin
                st_d.row[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // read is combinational: a write shows from the next cycle on
    assign rdata = st_q.row[raddr];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] upc
);

    typedef struct packed {
        logic [AW-1:0] pc;
    } seq_state_t;

    seq_state_t st_d, st_q;
    upc_act_e   act;

    // clear outranks load, load outranks step
    always_comb begin
        if (!rst_n) begin
            act = ACT_RESET;
        end else if (clr) begin
            act = ACT_CLEAR;
        end else if (ld) begin
            act = ACT_LOAD;
        end else begin
            act = ACT_STEP;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_RESET: st_d.pc = '0;
            ACT_CLEAR: st_d.pc = '0;
            ACT_LOAD:  st_d.pc = target;
            ACT_STEP:  st_d.pc = st_q.pc + AW'(1);
            default:   st_d.pc = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign upc = st_q.pc;

endmodule

// File: rtl/microseq_core.sv
module microseq_core
    import useq_pkg::*;
#(
    parameter int UPC_W = 6,
    parameter int CW_W  = 15,
    parameter int OP_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  bus_lo,
    input  logic             cs_we,
    input  logic [UPC_W-1:0] cs_waddr,
    input  logic [CW_W-1:0]  cs_wdata,
    input  logic             dec_we,
    input  logic [OP_W-1:0]  dec_waddr,
    input  logic [UPC_W-1:0] dec_wdata,
    output logic [CW_W-1:0]  ctrl_word,
    output logic [UPC_W-1:0] upc
);

    localparam int CS_DEPTH  = 1 << UPC_W;
    localparam int DEC_DEPTH = 1 << OP_W;

    logic [UPC_W-1:0] dec_target;

    useq_table #(
        .DEPTH (CS_DEPTH),
        .WIDTH (CW_W)
    ) u_store (
        .clk   (clk),
        .we    (cs_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata),
        .raddr (upc),
        .rdata (ctrl_word)
    );

    useq_table #(
        .DEPTH (DEC_DEPTH),
        .WIDTH (UPC_W)
    ) u_decode (
        .clk   (clk),
        .we    (dec_we),
        .waddr (dec_waddr),
        .wdata (dec_wdata),
        .raddr (bus_lo),
        .rdata (dec_target)
    );

    useq_next #(
        .AW (UPC_W)
    ) u_next (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctrl_word[CLR_IDX]),
        .ld     (ctrl_word[LD_IDX]),
        .target (dec_target),
        .upc    (upc)
    );

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    ctl_lo,
    input logic [AW-1:0] upc,
    input logic [AW-1:0] dec_target
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (upc == '0));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_lo[0])) |-> (upc == '0));

    // R5
    clear_over_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_lo == 2'b11)) |-> (upc == '0));

    // R4
    load_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_lo == 2'b10)) |-> (upc == $past(dec_target)));

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_lo == 2'b00)) |-> (upc == AW'($past(upc) + 1'b1)));

    // R7
    wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_lo == 2'b00) && ($past(upc) == {AW{1'b1}})) |-> (upc == '0));

endmodule

bind microseq_core useq_chk #(
    .AW (UPC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_lo     (ctrl_word[1:0]),
    .upc        (upc),
    .dec_target (dec_target)
);

// File: tb/sim_microseq_core.sv
module sim_microseq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_lo = '0;
    logic        cs_we = 1'b0;
    logic [5:0]  cs_waddr = '0;
    logic [14:0] cs_wdata = '0;
    logic        dec_we = 1'b0;
    logic [4:0]  dec_waddr = '0;
    logic [5:0]  dec_wdata = '0;
    logic [14:0] ctrl_word;
    logic [5:0]  upc;

    int checks = 0;
    int errors = 0;
    int ref_store [64];
    int ref_dec [32];
    int ref_upc = 0;
    string tag_pc = "R1";
    string extra = "";
    bit finished = 1'b0;
    int junk = 3;

    always #4 clk = ~clk;

    microseq_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_lo(bus_lo),
        .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
        .dec_we(dec_we), .dec_waddr(dec_waddr), .dec_wdata(dec_wdata),
        .ctrl_word(ctrl_word), .upc(upc)
    );

    // fetch word: load bit (2), memory read (3), PC to address bus (5), PC increment (6)
    localparam int FETCH = 15'h0036;

    function automatic int init_word(int a);
        int w;
        w = ((a * 37) ^ 16'h5A5) & 32'h7FFC;
        if (a == 0)  w = FETCH;
        if (a == 12) w = w | 1;   // clear only
        if (a == 20) w = w | 3;   // clear and load
        return w;
    endfunction

    task automatic check_outputs();
        checks++;
        if (upc !== 6'(ref_upc)) begin
            errors++;
            $display("FAIL %s %s upc: actual %0d expected %0d", tag_pc, extra, upc, ref_upc);
        end
        checks++;
        if (ctrl_word !== 15'(ref_store[ref_upc])) begin
            errors++;
            $display("FAIL R2 %s ctrl_word: actual %h expected %h", extra, ctrl_word,
                     15'(ref_store[ref_upc]));
        end
    endtask

    // one clock: inputs already driven after the previous falling edge
    task automatic tick();
        int w;
        int nxt;
        @(posedge clk);
        w = ref_store[ref_upc];
        if (!rst_n) begin
            nxt = 0; tag_pc = "R1";
        end else if ((w & 3) == 3) begin
            nxt = 0; tag_pc = "R5";
        end else if (w & 1) begin
            nxt = 0; tag_pc = "R3";
        end else if (w & 2) begin
            nxt = ref_dec[bus_lo]; tag_pc = "R4";   // old entry even if rewritten now (R8)
        end else begin
            nxt = (ref_upc + 1) % 64;
            tag_pc = (ref_upc == 63) ? "R7" : "R6,R10";
        end
        if (cs_we) ref_store[cs_waddr] = int'(cs_wdata);  // R9
        if (dec_we) ref_dec[dec_waddr] = int'(dec_wdata); // R8
        ref_upc = nxt;
        @(negedge clk);
        check_outputs();
        cs_we = 1'b0;
        dec_we = 1'b0;
        junk = (junk * 13 + 7) % 32;
        bus_lo = 5'(junk);   // R10: noise on the bus whenever no load is pending
    endtask

    task automatic run_op(int op);
        int n = 0;
        bus_lo = 5'(op);
        tick();
        while (ref_upc != 0 && n < 100) begin
            tick();
            n++;
        end
    endtask

    initial begin
        foreach (ref_store[i]) ref_store[i] = 0;
        foreach (ref_dec[i]) ref_dec[i] = 0;
        // R1: fill both tables while reset is held
        for (int a = 0; a < 64; a++) begin
            cs_we = 1'b1; cs_waddr = 6'(a); cs_wdata = 15'(init_word(a));
            if (a < 32) begin
                dec_we = 1'b1; dec_waddr = 5'(a); dec_wdata = 6'(8 + a);
            end
            tick();
        end
        rst_n = 1'b1;
        run_op(2);    // R3: 10,11,12 clear
        run_op(10);   // R5: 18,19,20 clear beats load
        run_op(20);   // R7: 28..63 then wrap
        // R8: rewrite entry 3 during the fetch that uses it
        extra = "R8";
        dec_we = 1'b1; dec_waddr = 5'd3; dec_wdata = 6'd50;
        run_op(3);    // old target 11
        run_op(3);    // new target 50
        // R9: clear bit written into 17 while fetching
        extra = "R9";
        cs_we = 1'b1; cs_waddr = 6'd17; cs_wdata = 15'h1001;
        run_op(7);    // 15,16,17 clear
        // R9: write the fetch word at the address being executed
        cs_we = 1'b1; cs_waddr = 6'd0; cs_wdata = 15'(FETCH | 16'h4000);
        run_op(1);
        run_op(4);
        extra = "";
        // R1: reset taken in the middle of a routine
        bus_lo = 5'd25;
        tick();
        for (int k = 0; k < 5; k++) tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        run_op(0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule